// File: doc/BRIEF.md
# 16x16 Luma Intra Prediction Generator

This block produces a 16x16 prediction of 8-bit luma pixels. It works from the pixels already reconstructed around the block: a row of 16 pixels directly above it, a column of 16 pixels directly to its left, and the single corner pixel above and to the left. A caller offers these neighbours together with a 2-bit prediction mode and two flags. The flags say whether the row above and the column to the left exist. The caller does this through a valid/ready start handshake.

Once the block accepts a job, it emits the prediction one row per beat over a second valid/ready handshake. Rows come out in raster order, and each beat carries all 16 pixels of one row. When the last row is taken, the block returns to idle and pulses a completion flag. A new job can then be offered.

Four predictors are supported:
- flat average (DC), with rounding that depends on which edges exist;
- vertical copy of the row above;
- horizontal copy of the left column;
- a gradient predictor that adds left-minus-corner to the row above and clamps the result to 0..255.

Top module: `ipred_gen16`

## Requirements
- R1: `start_ready` is high only while the block is idle. On a cycle where `start_valid` and `start_ready` are both high, the mode, both flags, the above row, the left column and the corner are captured. Changes on those inputs after acceptance have no effect on the rows of that job.
- R2: In the cycle after acceptance, `row_valid` is high and `row_index` is 0. Rows 0 to 15 then follow in order, and the index advances only on a cycle with `row_valid` and `row_ready` both high. While `row_valid` is high and `row_ready` is low, `row_index` and `row_data` hold. Pixel c of a row occupies `row_data[8*c+7:8*c]`. Neighbour pixel i occupies bits `[8*i+7:8*i]` of `above_row` and of `left_col`.
- R3: In the cycle after row 15 is accepted, `row_valid` is low, `start_ready` is high, and `done` is high for exactly that one cycle. `done` is low at all other times.
- R4: In mode 0 (DC), when both flags are low, every pixel is 128.
- R5: In mode 0, when exactly one flag is high, every pixel is (sum of the 16 pixels of the present edge + 8) >> 4.
- R6: In mode 0, when both flags are high, every pixel is (sum of all 32 edge pixels + 16) >> 5.
- R7: In mode 1 (vertical), every output row equals the above row.
- R8: In mode 2 (horizontal), all 16 pixels of row r equal left pixel r.
- R9: In mode 3 (gradient), pixel (r,c) is left[r] + above[c] - corner, computed signed without overflow and then clamped to 0..255.
- R10: While `rst_n` is low, and immediately after it is released, `row_valid` and `done` are low and `start_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | A prediction job is offered |
| start_ready | output | 1 | Block is idle and will accept a job |
| mode | input | 2 | 0 DC, 1 vertical, 2 horizontal, 3 gradient |
| above_avail | input | 1 | Row above is present |
| left_avail | input | 1 | Left column is present |
| above_row | input | 128 | 16 pixels above the block, pixel i at bits 8i+7:8i |
| left_col | input | 128 | 16 pixels left of the block, pixel i at bits 8i+7:8i |
| corner | input | 8 | Pixel above and to the left of the block |
| row_valid | output | 1 | A prediction row is presented |
| row_ready | input | 1 | Consumer takes the presented row |
| row_data | output | 128 | One row of 16 predicted pixels, pixel c at bits 8c+7:8c |
| row_index | output | 4 | Index of the presented row |
| done | output | 1 | One-cycle pulse after the last row is taken |

## Verification
A corrupted row counter shows up at the ports within one accepted beat. It appears as a skipped or repeated `row_index`, as a horizontal or gradient row built from the wrong left pixel, or as `done` arriving early or late. A capture register that is loaded at the wrong time, or loaded from live inputs, gives a wrong pixel value on the first row. That failure is seen because the bench scrambles the inputs right after acceptance. A wrong DC shift or rounding term shows up on every pixel of row 0 in the cycle after acceptance. The bench therefore includes a sum whose rounded and truncated averages differ. It also includes gradient cases that clamp at both limits, so a narrow or unsigned intermediate is exposed.

// File: rtl/ipred_pkg.sv
package ipred_pkg;

  typedef enum logic [1:0] {
    PM_DC   = 2'd0,
    PM_VERT = 2'd1,
    PM_HORZ = 2'd2,
    PM_GRAD = 2'd3
  } pred_mode_e;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_EMIT = 1'b1
  } seq_state_e;

endpackage

// File: rtl/ipred_seq.sv
module ipred_seq
  import ipred_pkg::*;
#(
  parameter int ROWS = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_valid,
  output logic                      start_ready,
  output logic                      load_en,
  output logic                      row_valid,
  input  logic                      row_ready,
  output logic [$clog2(ROWS)-1:0]   row_idx,
  output logic                      done
);

  localparam int IDX_W = $clog2(ROWS);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ROWS - 1);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             done_q, done_d;

  assign start_ready = (state_q == SQ_IDLE);
  assign row_valid   = (state_q == SQ_EMIT);
  assign load_en     = start_valid && start_ready;
  assign row_idx     = cnt_q;
  assign done        = done_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    done_d  = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (start_valid) begin
          state_d = SQ_EMIT;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      SQ_EMIT: begin
        if (row_ready) begin
          if (cnt_q == LAST) begin
            state_d = SQ_IDLE;
            done_d  = 1'b1;
          end else begin
            cnt_d  = cnt_q + 1'b1;
            cnt_en = 1'b1;
          end
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R2: an accepted job presents row 0 on the next cycle
  p_accept_row0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid && start_ready |=> row_valid && (row_idx == '0));

  // R2: a taken row that is not the last advances the index by one
  p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid && row_ready && (row_idx != LAST)
      |=> row_valid && (row_idx == IDX_W'($past(row_idx) + 1'b1)));

  // R3: taking the last row ends the job with a completion pulse
  p_last_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid && row_ready && (row_idx == LAST)
      |=> done && !row_valid && start_ready);

  // R3: the completion flag lasts a single cycle
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/ipred_dc.sv
module ipred_dc #(
  parameter int N     = 16,
  parameter int PIX_W = 8
) (
  input  logic [N*PIX_W-1:0] above,
  input  logic [N*PIX_W-1:0] left,
  input  logic               above_ok,
  input  logic               left_ok,
  output logic [PIX_W-1:0]   dc
);

  localparam int LOG2N = $clog2(N);
  localparam int SUM_W = PIX_W + LOG2N + 1;

  logic [SUM_W-1:0] sum_a, sum_l, sum_b;

  always_comb begin
    sum_a = '0;
    sum_l = '0;
    for (int i = 0; i < N; i++) begin
      sum_a = sum_a + SUM_W'(above[i*PIX_W +: PIX_W]);
      sum_l = sum_l + SUM_W'(left[i*PIX_W +: PIX_W]);
    end
    sum_b = sum_a + sum_l;
  end

  always_comb begin
    unique case ({above_ok, left_ok})
      2'b11:   dc = PIX_W'((sum_b + SUM_W'(N)) >> (LOG2N + 1));
      2'b10:   dc = PIX_W'((sum_a + SUM_W'(N / 2)) >> LOG2N);
      2'b01:   dc = PIX_W'((sum_l + SUM_W'(N / 2)) >> LOG2N);
      default: dc = PIX_W'(1 << (PIX_W - 1));
    endcase
  end

endmodule

// File: rtl/ipred_row.sv
module ipred_row
  import ipred_pkg::*;
#(
  parameter int N     = 16,
  parameter int PIX_W = 8
) (
  input  pred_mode_e            mode,
  input  logic [N*PIX_W-1:0]    above,
  input  logic [N*PIX_W-1:0]    left,
  input  logic [PIX_W-1:0]      corner,
  input  logic [PIX_W-1:0]      dc,
  input  logic [$clog2(N)-1:0]  row_idx,
  output logic [N*PIX_W-1:0]    row
);

  localparam int TW = PIX_W + 3;
  localparam logic signed [TW-1:0] PMAX = TW'((1 << PIX_W) - 1);

  logic [PIX_W-1:0]        left_pix;
  logic signed [TW-1:0]    grad;

  assign left_pix = left[row_idx*PIX_W +: PIX_W];
  assign grad     = $signed({3'b000, left_pix}) - $signed({3'b000, corner});

  for (genvar c = 0; c < N; c++) begin : g_col
    logic [PIX_W-1:0]     up_pix;
    logic signed [TW-1:0] tm;
    logic [PIX_W-1:0]     tm_clip;

    assign up_pix = above[c*PIX_W +: PIX_W];
    assign tm     = grad + $signed({3'b000, up_pix});

    always_comb begin
      if (tm < 0)         tm_clip = '0;
      else if (tm > PMAX) tm_clip = '1;
      else                tm_clip = tm[PIX_W-1:0];
    end

    always_comb begin
      unique case (mode)
        PM_VERT: row[c*PIX_W +: PIX_W] = up_pix;
        PM_HORZ: row[c*PIX_W +: PIX_W] = left_pix;
        PM_GRAD: row[c*PIX_W +: PIX_W] = tm_clip;
        default: row[c*PIX_W +: PIX_W] = dc;
      endcase
    end
  end

endmodule

// File: rtl/ipred_gen16.sv
module ipred_gen16
  import ipred_pkg::*;
#(
  parameter int N     = 16,
  parameter int PIX_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_valid,
  output logic                  start_ready,
  input  logic [1:0]            mode,
  input  logic                  above_avail,
  input  logic                  left_avail,
  input  logic [N*PIX_W-1:0]    above_row,
  input  logic [N*PIX_W-1:0]    left_col,
  input  logic [PIX_W-1:0]      corner,
  output logic                  row_valid,
  input  logic                  row_ready,
  output logic [N*PIX_W-1:0]    row_data,
  output logic [$clog2(N)-1:0]  row_index,
  output logic                  done
);

  localparam int IDX_W = $clog2(N);

  logic               load_en;
  pred_mode_e         mode_q;
  logic               aok_q, lok_q;
  logic [N*PIX_W-1:0] above_q, left_q;
  logic [PIX_W-1:0]   corner_q;
  logic [PIX_W-1:0]   dc_val;
  logic [IDX_W-1:0]   idx;

  ipred_seq #(.ROWS(N)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_valid (start_valid),
    .start_ready (start_ready),
    .load_en     (load_en),
    .row_valid   (row_valid),
    .row_ready   (row_ready),
    .row_idx     (idx),
    .done        (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= PM_DC;
      aok_q    <= 1'b0;
      lok_q    <= 1'b0;
      above_q  <= '0;
      left_q   <= '0;
      corner_q <= '0;
    end else if (load_en) begin
      mode_q   <= pred_mode_e'(mode);
      aok_q    <= above_avail;
      lok_q    <= left_avail;
      above_q  <= above_row;
      left_q   <= left_col;
      corner_q <= corner;
    end
  end

  ipred_dc #(.N(N), .PIX_W(PIX_W)) u_dc (
    .above    (above_q),
    .left     (left_q),
    .above_ok (aok_q),
    .left_ok  (lok_q),
    .dc       (dc_val)
  );

  ipred_row #(.N(N), .PIX_W(PIX_W)) u_row (
    .mode    (mode_q),
    .above   (above_q),
    .left    (left_q),
    .corner  (corner_q),
    .dc      (dc_val),
    .row_idx (idx),
    .row     (row_data)
  );

  assign row_index = idx;

  // R2: a stalled row keeps its index and pixels
  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid && !row_ready
      |=> row_valid && $stable(row_index) && $stable(row_data));

  // R1: no job is offered to the consumer while the block is idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready |-> !row_valid);

endmodule

// File: tb/ipred_gen16_bench.sv
module ipred_gen16_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [127:0] data;
    int           idx;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_valid = 1'b0;
  logic         start_ready;
  logic [1:0]   mode = 2'd0;
  logic         above_avail = 1'b0;
  logic         left_avail = 1'b0;
  logic [127:0] above_row = '0;
  logic [127:0] left_col = '0;
  logic [7:0]   corner = '0;
  logic         row_valid;
  logic         row_ready = 1'b1;
  logic [127:0] row_data;
  logic [3:0]   row_index;
  logic         done;

  int checks = 0;
  int failures = 0;
  int blocks_done = 0;
  bit ready_rand = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic [7:0] t_above [16];
  logic [7:0] t_left [16];
  exp_t sb [$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  ipred_gen16 u_ipred_gen16 (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_valid (start_valid),
    .start_ready (start_ready),
    .mode        (mode),
    .above_avail (above_avail),
    .left_avail  (left_avail),
    .above_row   (above_row),
    .left_col    (left_col),
    .corner      (corner),
    .row_valid   (row_valid),
    .row_ready   (row_ready),
    .row_data    (row_data),
    .row_index   (row_index),
    .done        (done)
  );

  task automatic check(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_pix(int m, bit ao, bit lo, logic [7:0] cn, int r, int c);
    int s, n, sh, v;
    case (m)
      1: return t_above[c];
      2: return t_left[r];
      3: begin
        v = int'(t_left[r]) + int'(t_above[c]) - int'(cn);
        if (v < 0) v = 0;
        if (v > 255) v = 255;
        return 8'(v);
      end
      default: begin
        s = 0; n = 0;
        if (ao) begin n++; for (int i = 0; i < 16; i++) s += int'(t_above[i]); end
        if (lo) begin n++; for (int i = 0; i < 16; i++) s += int'(t_left[i]); end
        if (n == 0) return 8'd128;
        sh = 3 + n;
        return 8'((s + (1 << (sh - 1))) >> sh);
      end
    endcase
  endfunction

  // Driver: push the expected rows, offer the job, then scramble inputs (R1)
  task automatic run_case(int m, bit ao, bit lo, logic [7:0] cn, string tag);
    exp_t e;
    bit acc;
    int target;
    target = blocks_done + 1;
    for (int r = 0; r < 16; r++) begin
      for (int c = 0; c < 16; c++) e.data[c*8 +: 8] = ref_pix(m, ao, lo, cn, r, c);
      e.idx = r;
      e.tag = tag;
      sb.push_back(e);
    end
    @(posedge clk); #1;
    mode = 2'(m); above_avail = ao; left_avail = lo; corner = cn;
    for (int i = 0; i < 16; i++) begin
      above_row[i*8 +: 8] = t_above[i];
      left_col[i*8 +: 8]  = t_left[i];
    end
    start_valid = 1'b1;
    do begin
      @(negedge clk); acc = start_ready;
      @(posedge clk); #1;
    end while (!acc);
    start_valid = 1'b0;
    mode = ~mode; above_avail = ~ao; left_avail = ~lo; corner = ~cn;
    above_row = ~above_row; left_col = {left_col[63:0], ~left_col[127:64]};
    while (blocks_done < target) @(negedge clk);
  endtask

  // Consumer ready pattern
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    row_ready = ready_rand ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  // Monitor: pop and compare as rows are taken
  bit expect_done = 1'b0;
  bit stall_prev = 1'b0;
  logic [127:0] stall_data;
  logic [3:0]   stall_idx;
  always @(negedge clk) begin
    exp_t e;
    if (rst_n) begin
      if (expect_done) begin
        check(done && !row_valid && start_ready, "R3", "end of job",
              {125'd0, done, row_valid, start_ready}, 128'd5);
        expect_done = 1'b0;
        blocks_done++;
      end else if (done) begin
        check(1'b0, "R3", "stray done", 128'd1, 128'd0);
      end
      if (stall_prev && row_valid)
        check(row_data == stall_data && row_index == stall_idx, "R2", "stall hold",
              row_data, stall_data);
      if (row_valid && row_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R2", "unexpected row", {124'd0, row_index}, 128'd0);
        end else begin
          e = sb.pop_front();
          check(row_data == e.data, e.tag, "row pixels (R1 capture)", row_data, e.data);
          check(int'(row_index) == e.idx, "R2", "row order",
                {124'd0, row_index}, 128'(e.idx));
          if (e.idx == 15) expect_done = 1'b1;
        end
      end
      stall_prev = row_valid && !row_ready;
      stall_data = row_data;
      stall_idx  = row_index;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!row_valid && !done && start_ready, "R10", "in reset",
          {125'd0, row_valid, done, start_ready}, 128'd1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(!row_valid && !done && start_ready, "R10", "after release",
          {125'd0, row_valid, done, start_ready}, 128'd1);

    for (int i = 0; i < 16; i++) begin
      t_above[i] = 8'(7 + 13 * i);
      t_left[i]  = 8'(200 - 9 * i);
    end
    run_case(0, 1'b0, 1'b0, 8'd40, "R4");
    run_case(0, 1'b1, 1'b0, 8'd40, "R5");
    run_case(0, 1'b0, 1'b1, 8'd40, "R5");
    run_case(0, 1'b1, 1'b1, 8'd40, "R6");
    run_case(1, 1'b1, 1'b1, 8'd40, "R7");
    run_case(2, 1'b1, 1'b1, 8'd40, "R8");
    run_case(3, 1'b1, 1'b1, 8'd128, "R9");

    // rounding: sum 168, rounded 11, truncated 10
    for (int i = 0; i < 16; i++) t_above[i] = (i == 5) ? 8'd18 : 8'd10;
    run_case(0, 1'b1, 1'b0, 8'd0, "R5");
    for (int i = 0; i < 16; i++) t_left[i] = 8'(i == 0 ? 20 : 2);
    run_case(0, 1'b1, 1'b1, 8'd0, "R6");

    // gradient saturating high and low
    for (int i = 0; i < 16; i++) begin
      t_above[i] = 8'(240 + i);
      t_left[i]  = 8'(250 - i);
    end
    run_case(3, 1'b1, 1'b1, 8'd5, "R9");
    for (int i = 0; i < 16; i++) begin
      t_above[i] = 8'(i * 3);
      t_left[i]  = 8'(i * 2);
    end
    run_case(3, 1'b1, 1'b1, 8'd250, "R9");

    // stalling consumer
    ready_rand = 1'b1;
    for (int i = 0; i < 16; i++) begin
      t_above[i] = 8'(31 * i + 3);
      t_left[i]  = 8'(17 * i + 90);
    end
    run_case(2, 1'b0, 1'b1, 8'd77, "R8");
    run_case(3, 1'b1, 1'b1, 8'd100, "R9");
    run_case(0, 1'b1, 1'b1, 8'd0, "R6");
    ready_rand = 1'b0;

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R2", "all rows delivered", 128'(sb.size()), 128'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule